// File: doc/BRIEF.md
# Raster Display Interrupt Status Unit

This unit gathers the interrupt events of a raster-mode display controller and keeps them in a seven-bit raw status register. The DMA and video timing logic send it single-cycle pulses: pixel FIFO underrun, frame sync lost, palette load finished, frame transfer done, and end of frame for buffer 0 or buffer 1. The unit also counts AC-bias line transitions and raises its own status bit when a programmed count runs out. Each status bit, masked by its own enable bit, feeds one registered interrupt line.

The status bits do not all clear the same way. The underrun, sync-lost, frame-done and both end-of-frame bits stay set until the raster enable input goes low. Software writes have no effect on them. The palette bit clears when software writes 0 to it, except in palette-only mode, where only disabling the raster clears it. The AC-bias bit clears when software writes 0 to it.

The AC-bias counter is a three-state machine. In ACB_IDLE the reload value is zero and nothing is counted. ACB_IDLE goes to ACB_COUNT when the reload value is nonzero, and the counter loads that value. In ACB_COUNT every line edge decrements the counter. When the counter is at one, the next edge sets the status bit, reloads the counter and moves to ACB_HOLD. ACB_HOLD ignores edges and returns to ACB_COUNT once the status bit reads clear. ACB_COUNT and ACB_HOLD both drop to ACB_IDLE whenever the reload value becomes zero.

Top module: `rast_irq_unit`

## Requirements
- R1: After reset, `status` and `irq` are both 0.
- R2: Status bit 0 (underrun) and bit 1 (sync lost) set on their event pulse. While `raster_en` is 1 they stay set whatever is written. They clear on the clock edge where `raster_en` is 0.
- R3: Status bit 4 (frame done), bit 5 (end of frame, buffer 0) and bit 6 (end of frame, buffer 1) set on their pulses and follow the same clear rule as R2.
- R4: Status bit 2 (palette loaded) sets on its pulse. When `pal_mode` is not 1 (0 = palette plus data, 2 = data only, 3 = treated as 2), a write with `wr_en` = 1 and `wr_data[2]` = 0 clears it. A write with `wr_data[2]` = 1 leaves it unchanged.
- R5: When `pal_mode` = 1 (palette only), writes do not affect bit 2, and bit 2 clears on the clock edge where `raster_en` is 0.
- R6: With a nonzero `acb_reload` value of N, status bit 3 sets on the N-th change of `acb_line` after counting starts. Rising and falling changes both count, and each is detected against a one-cycle delayed copy of the line.
- R7: After bit 3 sets, line changes are ignored until software clears bit 3 by writing 0 to `wr_data[3]`. Counting then restarts from `acb_reload`. `raster_en` does not affect bit 3.
- R8: While `acb_reload` is 0, bit 3 never sets, however much `acb_line` toggles.
- R9: If a set event and a software clear of the same bit happen in the same cycle, the bit ends up set.
- R10: `irq` is the registered OR of `status & irq_en`. It goes high one cycle after an enabled bit sets and stays low when no set bit is enabled.
- R11: While `raster_en` is 0, pulses for bits 0, 1, 4, 5 and 6 have no effect. In palette-only mode this also applies to bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raster_en | input | 1 | Raster enable; low clears the sticky bits |
| pal_mode | input | 2 | Palette mode: 0 palette plus data, 1 palette only, 2 data only |
| ev_underrun | input | 1 | FIFO underrun pulse |
| ev_sync_lost | input | 1 | Frame sync lost pulse |
| ev_pal_done | input | 1 | Palette load finished pulse |
| ev_frame_done | input | 1 | Frame transfer complete pulse |
| ev_eof0 | input | 1 | End of frame, buffer 0 |
| ev_eof1 | input | 1 | End of frame, buffer 1 |
| acb_line | input | 1 | AC-bias line |
| acb_reload | input | CW (8) | AC-bias transition count; 0 disables counting |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 7 | Write data; a 0 clears a clearable bit |
| irq_en | input | 7 | Per-bit interrupt enables |
| status | output | 7 | Raw status bits |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The embedded assertions check these on every cycle:
- the sticky bits hold while the raster is enabled;
- the sticky bits are empty after any cycle with the raster disabled;
- a palette pulse always leaves bit 2 set;
- a counter hit always sets bit 3;
- the interrupt stays low one cycle after no enabled bit is set;
- the counter returns to ACB_IDLE once the reload value is zero.

Only the bench scenarios can show the exact transition count before bit 3 sets, the restart from the reload value after software acknowledges, and that pulses are ignored while the raster is disabled. The bench checks these against a cycle model, together with random mixes of events, writes and mode changes.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
    localparam int NSRC   = 7;
    localparam int B_UNDER = 0;
    localparam int B_SYNC  = 1;
    localparam int B_PAL   = 2;
    localparam int B_ACB   = 3;
    localparam int B_DONE  = 4;
    localparam int B_EOF0  = 5;
    localparam int B_EOF1  = 6;
    localparam logic [NSRC-1:0] RUN_STICKY = 7'b111_0011;
    localparam logic [NSRC-1:0] PAL_BIT    = 7'b000_0100;
    localparam logic [NSRC-1:0] ACB_BIT    = 7'b000_1000;
    localparam logic [1:0]      PAL_ONLY   = 2'd1;

    typedef enum logic [1:0] {
        ACB_IDLE  = 2'd0,
        ACB_COUNT = 2'd1,
        ACB_HOLD  = 2'd2
    } acb_state_e;
endpackage

// File: rtl/rirq_acb_fsm.sv
module rirq_acb_fsm
    import rirq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_i,
    input  logic [CW-1:0] reload_i,
    input  logic          ack_i,
    output logic          hit_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    acb_state_e    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          line_q;
    logic          edge_seen;
    logic          reload_nz;

    assign edge_seen = line_i ^ line_q;
    assign reload_nz = (reload_i != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACB_IDLE;
            cnt_q   <= '0;
            line_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            line_q  <= line_i;
        end
    end

    always_comb begin
        hit_o = (state_q == ACB_COUNT) && reload_nz && edge_seen && (cnt_q == ONE);
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ACB_IDLE: begin
                if (reload_nz) begin
                    state_n = ACB_COUNT;
                    cnt_n   = reload_i;
                end
            end
            ACB_COUNT: begin
                if (!reload_nz) begin
                    state_n = ACB_IDLE;
                end else if (hit_o) begin
                    state_n = ACB_HOLD;
                    cnt_n   = reload_i;
                end else if (edge_seen) begin
                    cnt_n = cnt_q - ONE;
                end
            end
            ACB_HOLD: begin
                if (!reload_nz) begin
                    state_n = ACB_IDLE;
                end else if (ack_i) begin
                    state_n = ACB_COUNT;
                end
            end
            default: state_n = ACB_IDLE;
        endcase
    end

    AST_ZERO_RELOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i == '0) |=> (state_q == ACB_IDLE)); // R8
    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACB_COUNT) |-> (cnt_q != '0)); // R6
endmodule

// File: rtl/rirq_status_bank.sv
module rirq_status_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] swclr_i,
    input  logic [N-1:0] forceclr_i,
    output logic [N-1:0] status_o
);
    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_o[gi] <= 1'b0;
            end else if (forceclr_i[gi]) begin
                status_o[gi] <= 1'b0;
            end else if (set_i[gi]) begin
                status_o[gi] <= 1'b1;
            end else if (swclr_i[gi]) begin
                status_o[gi] <= 1'b0;
            end
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & swclr_i & ~forceclr_i)) |=> (|status_o)); // R9
endmodule

// File: rtl/rirq_irq_combine.sv
module rirq_irq_combine #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);
    logic [N-1:0] masked;

    for (genvar gi = 0; gi < N; gi++) begin : g_mask
        assign masked[gi] = status_i[gi] & en_i[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |masked;
    end
endmodule

// File: rtl/rast_irq_unit.sv
module rast_irq_unit
    import rirq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raster_en,
    input  logic [1:0]         pal_mode,
    input  logic               ev_underrun,
    input  logic               ev_sync_lost,
    input  logic               ev_pal_done,
    input  logic               ev_frame_done,
    input  logic               ev_eof0,
    input  logic               ev_eof1,
    input  logic               acb_line,
    input  logic [CW-1:0]      acb_reload,
    input  logic               wr_en,
    input  logic [NSRC-1:0]    wr_data,
    input  logic [NSRC-1:0]    irq_en,
    output logic [NSRC-1:0]    status,
    output logic               irq
);
    logic            acb_hit;
    logic            pal_only;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] sw_mask;
    logic [NSRC-1:0] swclr;
    logic [NSRC-1:0] dis_clr;

    assign pal_only = (pal_mode == PAL_ONLY);

    always_comb begin
        set_vec          = '0;
        set_vec[B_UNDER] = ev_underrun;
        set_vec[B_SYNC]  = ev_sync_lost;
        set_vec[B_PAL]   = ev_pal_done;
        set_vec[B_ACB]   = acb_hit;
        set_vec[B_DONE]  = ev_frame_done;
        set_vec[B_EOF0]  = ev_eof0;
        set_vec[B_EOF1]  = ev_eof1;
        sw_mask = ACB_BIT | (pal_only ? '0 : PAL_BIT);
        swclr   = wr_en ? (~wr_data & sw_mask) : '0;
        dis_clr = raster_en ? '0 : (RUN_STICKY | (pal_only ? PAL_BIT : '0));
    end

    rirq_acb_fsm #(.CW(CW)) acb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (acb_line),
        .reload_i (acb_reload),
        .ack_i    (!status[B_ACB]),
        .hit_o    (acb_hit)
    );

    rirq_status_bank #(.N(NSRC)) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .swclr_i    (swclr),
        .forceclr_i (dis_clr),
        .status_o   (status)
    );

    rirq_irq_combine #(.N(NSRC)) comb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .en_i     (irq_en),
        .irq_o    (irq)
    );

    AST_UNDER_SYNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (raster_en && (|status[B_SYNC:B_UNDER])) |=> (|status[B_SYNC:B_UNDER])); // R2
    AST_FRAME_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (raster_en && status[B_DONE]) |=> status[B_DONE]); // R3
    AST_PAL_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (raster_en && (pal_mode == PAL_ONLY) && status[B_PAL]) |=> status[B_PAL]); // R5
    AST_PAL_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pal_done && !(!raster_en && pal_mode == PAL_ONLY)) |=> status[B_PAL]); // R4
    AST_HIT_SETS_ACB: assert property (@(posedge clk) disable iff (!rst_n)
        acb_hit |=> status[B_ACB]); // R6
    AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !raster_en |=> ((status[B_SYNC:B_UNDER] == '0) && (status[B_EOF1:B_DONE] == '0))); // R11
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & irq_en) == '0) |=> !irq); // R10
endmodule

// File: tb/rast_irq_unit_tb.sv
module rast_irq_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raster_en = 1'b0;
    logic [1:0] pal_mode = 2'd0;
    logic       ev_underrun = 1'b0, ev_sync_lost = 1'b0, ev_pal_done = 1'b0;
    logic       ev_frame_done = 1'b0, ev_eof0 = 1'b0, ev_eof1 = 1'b0;
    logic       acb_line = 1'b0;
    logic [7:0] acb_reload = 8'd0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_data = 7'h7f;
    logic [6:0] irq_en = 7'h00;
    logic [6:0] status;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    logic [6:0] m_st = '0;
    logic       m_irq = 1'b0;
    int         m_state = 0;
    logic [7:0] m_cnt = '0;
    logic       m_lq = 1'b0;

    always #10 clk = ~clk;

    rast_irq_unit #(.CW(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .pal_mode(pal_mode),
        .ev_underrun(ev_underrun), .ev_sync_lost(ev_sync_lost), .ev_pal_done(ev_pal_done),
        .ev_frame_done(ev_frame_done), .ev_eof0(ev_eof0), .ev_eof1(ev_eof1),
        .acb_line(acb_line), .acb_reload(acb_reload), .wr_en(wr_en), .wr_data(wr_data),
        .irq_en(irq_en), .status(status), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] next_status(logic [6:0] st, logic hit);
        logic [6:0] s, dis, sw;
        s   = {ev_eof1, ev_eof0, ev_frame_done, hit, ev_pal_done, ev_sync_lost, ev_underrun};
        dis = raster_en ? 7'h00 : (7'b1110011 | ((pal_mode == 2'd1) ? 7'b0000100 : 7'h00));
        sw  = wr_en ? (~wr_data & (7'b0001000 | ((pal_mode != 2'd1) ? 7'b0000100 : 7'h00))) : 7'h00;
        return ((st & ~sw) | s) & ~dis;
    endfunction

    task automatic cyc();
        logic edg, hit;
        @(posedge clk);
        edg = acb_line ^ m_lq;
        hit = (m_state == 1) && (acb_reload != 0) && edg && (m_cnt == 8'd1);
        case (m_state)
            0: if (acb_reload != 0) begin m_state = 1; m_cnt = acb_reload; end
            1: if (acb_reload == 0) m_state = 0;
               else if (hit) begin m_state = 2; m_cnt = acb_reload; end
               else if (edg) m_cnt = m_cnt - 8'd1;
            default: if (acb_reload == 0) m_state = 0;
                     else if (!m_st[3]) m_state = 1;
        endcase
        m_irq = |(m_st & irq_en);
        m_st  = next_status(m_st, hit);
        m_lq  = acb_line;
        @(negedge clk);
        chk({cur_req, " status"}, 32'(status), 32'(m_st));
        chk({cur_req, " irq"}, 32'(irq), 32'(m_irq));
    endtask

    task automatic wclr(logic [6:0] d);
        wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0; wr_data = 7'h7f;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 reset status", 32'(status), 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        raster_en = 1'b1;
        cyc();

        // R2: underrun/sync survive writes, cleared by disable
        cur_req = "R2";
        ev_underrun = 1'b1; ev_sync_lost = 1'b1; cyc(); ev_underrun = 1'b0; ev_sync_lost = 1'b0;
        wclr(7'h00);
        chk("R2 held after write", 32'(status[1:0]), 32'h3);
        raster_en = 1'b0; cyc(); raster_en = 1'b1;
        chk("R2 cleared by disable", 32'(status[1:0]), 32'h0);

        // R3: frame done and eof bits
        cur_req = "R3";
        ev_frame_done = 1'b1; ev_eof1 = 1'b1; cyc(); ev_frame_done = 1'b0; ev_eof1 = 1'b0;
        ev_eof0 = 1'b1; cyc(); ev_eof0 = 1'b0;
        wclr(7'h00);
        chk("R3 held", 32'(status[6:4]), 32'h7);
        raster_en = 1'b0; cyc(); raster_en = 1'b1;
        chk("R3 cleared", 32'(status[6:4]), 32'h0);

        // R4: palette in mode 0 and 2
        cur_req = "R4";
        pal_mode = 2'd0;
        ev_pal_done = 1'b1; cyc(); ev_pal_done = 1'b0;
        wclr(7'h7f);
        chk("R4 write 1 keeps", 32'(status[2]), 32'h1);
        wclr(7'h7b);
        chk("R4 write 0 clears mode0", 32'(status[2]), 32'h0);
        pal_mode = 2'd2;
        ev_pal_done = 1'b1; cyc(); ev_pal_done = 1'b0;
        wclr(7'h7b);
        chk("R4 write 0 clears mode2", 32'(status[2]), 32'h0);

        // R5: palette-only mode
        cur_req = "R5";
        pal_mode = 2'd1;
        ev_pal_done = 1'b1; cyc(); ev_pal_done = 1'b0;
        wclr(7'h00);
        chk("R5 write ignored", 32'(status[2]), 32'h1);
        raster_en = 1'b0; cyc(); raster_en = 1'b1;
        chk("R5 cleared by disable", 32'(status[2]), 32'h0);
        pal_mode = 2'd0;

        // R6 / R7: AC-bias counting, hold and restart
        cur_req = "R6";
        acb_reload = 8'd3; cyc();
        acb_line = ~acb_line; cyc();
        acb_line = ~acb_line; cyc();
        chk("R6 two edges no set", 32'(status[3]), 32'h0);
        acb_line = ~acb_line; cyc();
        chk("R6 third edge sets", 32'(status[3]), 32'h1);
        cur_req = "R7";
        for (int i = 0; i < 4; i++) begin acb_line = ~acb_line; cyc(); end
        wclr(7'h77);
        chk("R7 ack clears", 32'(status[3]), 32'h0);
        cyc();
        acb_line = ~acb_line; cyc();
        acb_line = ~acb_line; cyc();
        chk("R7 held edges ignored", 32'(status[3]), 32'h0);
        acb_line = ~acb_line; cyc();
        chk("R7 restart from reload", 32'(status[3]), 32'h1);
        wclr(7'h77);

        // R8: zero reload disables counting
        cur_req = "R8";
        acb_reload = 8'd0; cyc();
        for (int i = 0; i < 20; i++) begin acb_line = ~acb_line; cyc(); end
        chk("R8 never sets", 32'(status[3]), 32'h0);

        // R9: set and clear together
        cur_req = "R9";
        ev_pal_done = 1'b1; wr_en = 1'b1; wr_data = 7'h00; cyc();
        ev_pal_done = 1'b0; wr_en = 1'b0; wr_data = 7'h7f;
        chk("R9 set wins", 32'(status[2]), 32'h1);

        // R10: interrupt masking and latency
        cur_req = "R10";
        irq_en = 7'h01;
        chk("R10 masked quiet", 32'(irq), 32'h0);
        ev_underrun = 1'b1; cyc(); ev_underrun = 1'b0;
        chk("R10 not yet", 32'(irq), 32'h0);
        cyc();
        chk("R10 one cycle later", 32'(irq), 32'h1);
        raster_en = 1'b0; cyc(); cyc();
        chk("R10 drops", 32'(irq), 32'h0);

        // R11: events ignored while disabled
        cur_req = "R11";
        ev_underrun = 1'b1; ev_sync_lost = 1'b1; ev_frame_done = 1'b1; ev_eof0 = 1'b1; ev_eof1 = 1'b1;
        cyc();
        ev_underrun = 1'b0; ev_sync_lost = 1'b0; ev_frame_done = 1'b0; ev_eof0 = 1'b0; ev_eof1 = 1'b0;
        chk("R11 ignored", 32'(status & 7'b1110011), 32'h0);
        raster_en = 1'b1;
        wclr(7'h00);

        // Random mix: R2 R3 R4 R5 R6 R7 R9 R10
        cur_req = "R2-mix";
        for (int i = 0; i < 4000; i++) begin
            raster_en     = ($urandom_range(0, 19) != 0);
            if ($urandom_range(0, 49) == 0) pal_mode = 2'($urandom_range(0, 3));
            ev_underrun   = ($urandom_range(0, 29) == 0);
            ev_sync_lost  = ($urandom_range(0, 29) == 0);
            ev_pal_done   = ($urandom_range(0, 9) == 0);
            ev_frame_done = ($urandom_range(0, 19) == 0);
            ev_eof0       = ($urandom_range(0, 19) == 0);
            ev_eof1       = ($urandom_range(0, 19) == 0);
            acb_line      = ($urandom_range(0, 2) == 0) ? ~acb_line : acb_line;
            if ($urandom_range(0, 99) == 0) acb_reload = 8'($urandom_range(0, 4));
            wr_en         = ($urandom_range(0, 5) == 0);
            wr_data       = 7'($urandom);
            if ($urandom_range(0, 29) == 0) irq_en = 7'($urandom);
            cyc();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule